// File: doc/BRIEF.md
# Watchdog Timer with Reset Control

This block is an up-counting supervision timer. Software arms it by setting a run bit and choosing between two modes. In watchdog mode the counter must be reloaded before it wraps. If it wraps, a sticky overflow flag is set and the timer's own counter and control state are cleared. If reset generation is enabled, a fixed-length internal reset pulse is also driven. In interval mode the same wrap produces a one-cycle interrupt request, and the counter keeps running.

Every register write is keyed. A 16-bit write takes effect only when its upper byte equals a fixed key, and its lower byte carries the data. The reset control/status register is cleared only by the external reset pin, so it survives the reset pulse the block generates itself. Software can clear the overflow flag only by reading it as 1 first and then writing 0 to it.

All pins are plain control and status signals. No data stream crosses the edge, so there is no valid/ready pair. Reads are combinational on the read strobe, and writes complete in one clock.

Top module: `wdt_guard`

## Requirements
- R1: After the pin reset, the counter (address 0) reads 0 and the control register (address 1) reads 0. The reset register (address 2) reads 0x1F. The reset output and the interval request are low.
- R2: With run (control bit 0) set, the counter advances by one on each cycle with the tick high. With run clear, it holds. A keyed write to address 0 loads the counter.
- R3: A write changes a register only when `bus_wdata[15:8]` equals PASSWORD. Any other write leaves every register unchanged.
- R4: When the counter wraps from its maximum to 0 with control bit 1 set (watchdog mode), flag bit 7 of the reset register becomes 1. In interval mode (bit 1 clear) the flag is never set.
- R5: A wrap in interval mode drives `ival_irq_o` high for exactly the one cycle after the wrap edge. The counter continues from 0 with run unchanged.
- R6: A wrap in watchdog mode clears the counter and both control bits, whatever the reset enable holds.
- R7: When reset enable (bit 6) is 1, a watchdog wrap drives `sys_rst_o` high for exactly PULSE_LEN cycles, starting the cycle after the wrap. During the pulse, `rst_kind_o` carries bit 5. When reset enable is 0, no pulse occurs.
- R8: While `sys_rst_o` is high, the counter stays at 0, and writes to the counter and control registers are ignored.
- R9: The reset register keeps its contents through the generated reset pulse. Only the pin reset returns it to 0x1F.
- R10: The flag clears only on a keyed write to address 2 with bit 7 at 0, and only if an earlier read of address 2 returned bit 7 as 1 with no keyed write to address 2 in between. Writing 1 never sets the flag.
- R11: Bits 6 and 5 of the reset register follow keyed writes. Bits 4 to 0 always read 1 and ignore writes.
- R12: If a watchdog wrap and a valid flag clear fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset pin, active low, asynchronous |
| cnt_tick | input | 1 | Counter clock enable from the prescaler |
| bus_addr | input | 2 | Register select: 0 counter, 1 control, 2 reset register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Key in the upper byte, data in the lower byte |
| bus_rdata | output | 8 | Read data, zero when the read strobe is low |
| sys_rst_o | output | 1 | Internal reset pulse |
| rst_kind_o | output | 1 | Reset type select, valid while the pulse is high |
| ival_irq_o | output | 1 | Interval-mode overflow request, one cycle wide |

## Verification
The bench builds the block with a 4-bit counter and a 5-cycle reset pulse, keeping PASSWORD at 0x5A. The narrow counter lets the bench load every counter value and tick it once, so it sees every increment, the single wrap and the interval request without long waits. The short pulse makes it cheap to measure the pulse length exactly and to try writes while the pulse is high. Both reset-enable settings, the same-cycle set-and-clear case and each step of the flag-clearing protocol run in full.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int BUS_AW = 2;

  typedef enum logic [BUS_AW-1:0] {
    SEL_CNT  = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_RSR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int FLAG_BIT  = 7;
  localparam int RSTEN_BIT = 6;
  localparam int KIND_BIT  = 5;
  localparam logic [4:0] RSR_PAD = 5'b11111;

  localparam int RUN_BIT  = 0;
  localparam int MODE_BIT = 1;
endpackage

// File: rtl/wdt_busif.sv
module wdt_busif
  import wdt_guard_pkg::*;
#(
  parameter logic [7:0] PASSWORD = 8'h5A,
  parameter int CNT_W = 8
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [15:0]       wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              run,
  input  logic              wdt_mode,
  input  logic [7:0]        rsr_val,
  output logic              cnt_we,
  output logic              ctl_we,
  output logic              rsr_we,
  output logic              rsr_rd,
  output logic [7:0]        wbyte,
  output logic [7:0]        rdata
);
  logic     key_ok;
  reg_sel_e sel;

  assign key_ok = (wdata[15:8] == PASSWORD);
  assign sel    = reg_sel_e'(addr);
  assign wbyte  = wdata[7:0];

  always_comb begin
    cnt_we = 1'b0;
    ctl_we = 1'b0;
    rsr_we = 1'b0;
    if (wr && key_ok) begin
      unique case (sel)
        SEL_CNT: cnt_we = 1'b1;
        SEL_CTL: ctl_we = 1'b1;
        SEL_RSR: rsr_we = 1'b1;
        default: ;
      endcase
    end
  end

  assign rsr_rd = rd && (sel == SEL_RSR);

  always_comb begin
    rdata = 8'h00;
    if (rd) begin
      unique case (sel)
        SEL_CNT: rdata = 8'(cnt);
        SEL_CTL: rdata = 8'({wdt_mode, run});
        SEL_RSR: rdata = rsr_val;
        default: rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/wdt_tcount.sv
module wdt_tcount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic             cnt_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] cnt_wval,
  input  logic [1:0]       ctl_wval,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             wdt_mode,
  output logic             wdt_ovf,
  output logic             ival_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic wrap;

  assign wrap     = run && tick && (cnt == CNT_MAX) && !hold && !cnt_we;
  assign wdt_ovf  = wrap && wdt_mode;
  assign ival_ovf = wrap && !wdt_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hold || wdt_ovf) begin
      cnt <= '0;
    end else if (cnt_we) begin
      cnt <= cnt_wval;
    end else if (run && tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      wdt_mode <= 1'b0;
    end else if (hold || wdt_ovf) begin
      run      <= 1'b0;
      wdt_mode <= 1'b0;
    end else if (ctl_we) begin
      run      <= ctl_wval[0];
      wdt_mode <= ctl_wval[1];
    end
  end

  // R6
  wdt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> (cnt == '0) && !run && !wdt_mode);

  // R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));

  // R5
  ival_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ival_ovf |=> (cnt == '0) && run && !wdt_mode);
endmodule

// File: rtl/wdt_rstpulse.sv
module wdt_rstpulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kind_in,
  output logic active,
  output logic kind_out
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LEN_V = PW'(PULSE_LEN);

  logic [PW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain   <= '0;
      kind_out <= 1'b0;
    end else if (start) begin
      remain   <= LEN_V;
      kind_out <= kind_in;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign active = (remain != '0);

  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active);

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int         CNT_W     = 8,
  parameter int         PULSE_LEN = 16,
  parameter logic [7:0] PASSWORD  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sys_rst_o,
  output logic              rst_kind_o,
  output logic              ival_irq_o
);
  logic             cnt_we, ctl_we, rsr_we, rsr_rd;
  logic [7:0]       wbyte;
  logic [CNT_W-1:0] cnt;
  logic             run, wdt_mode, wdt_ovf, ival_ovf;
  logic             flag, rst_en, rst_kind, armed;
  logic [7:0]       rsr_val;

  assign rsr_val = {flag, rst_en, rst_kind, RSR_PAD};

  wdt_busif #(.PASSWORD(PASSWORD), .CNT_W(CNT_W)) u_bus (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
    .cnt(cnt), .run(run), .wdt_mode(wdt_mode), .rsr_val(rsr_val),
    .cnt_we(cnt_we), .ctl_we(ctl_we), .rsr_we(rsr_we), .rsr_rd(rsr_rd),
    .wbyte(wbyte), .rdata(bus_rdata)
  );

  wdt_tcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .hold(sys_rst_o),
    .cnt_we(cnt_we), .ctl_we(ctl_we),
    .cnt_wval(wbyte[CNT_W-1:0]), .ctl_wval(wbyte[1:0]),
    .cnt(cnt), .run(run), .wdt_mode(wdt_mode),
    .wdt_ovf(wdt_ovf), .ival_ovf(ival_ovf)
  );

  wdt_rstpulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(wdt_ovf && rst_en),
    .kind_in(rst_kind), .active(sys_rst_o), .kind_out(rst_kind_o)
  );

  // Reset register: only the pin reset touches it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      rst_en   <= 1'b0;
      rst_kind <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (rsr_we) begin
        rst_en   <= wbyte[RSTEN_BIT];
        rst_kind <= wbyte[KIND_BIT];
      end
      if (wdt_ovf)
        flag <= 1'b1;
      else if (rsr_we && !wbyte[FLAG_BIT] && armed)
        flag <= 1'b0;
      if (rsr_we)
        armed <= 1'b0;
      else if (rsr_rd && flag)
        armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ival_irq_o <= 1'b0;
    else        ival_irq_o <= ival_ovf;
  end

  // R4
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wdt_ovf));

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> flag);

  // R10
  clear_proto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && rsr_we));

  // R5
  irq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ival_irq_o |=> !ival_irq_o);
endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
  localparam int CW = 4;
  localparam int PL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [7:0]  bus_rdata;
  logic        sys_rst_o, rst_kind_o, ival_irq_o;

  int checks = 0;
  int fails = 0;

  wdt_guard #(.CNT_W(CW), .PULSE_LEN(PL), .PASSWORD(8'h5A)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_rst_o(sys_rst_o),
    .rst_kind_o(rst_kind_o), .ival_irq_o(ival_irq_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic pin_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int q);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 q = int'(bus_rdata);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk); cnt_tick = 1'b1;
    @(negedge clk); cnt_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int q;
    int n;
    pin_reset();
    // R1
    check("R1 sys_rst", int'(sys_rst_o), 0);
    check("R1 irq", int'(ival_irq_o), 0);
    rd(0, q); check("R1 counter", q, 0);
    rd(1, q); check("R1 control", q, 0);
    rd(2, q); check("R1 reset reg", q, 8'h1F);

    // R3: wrong key is ignored on every register
    wr(1, 16'h1203); rd(1, q); check("R3 control", q, 0);
    wr(0, 16'hA509); rd(0, q); check("R3 counter", q, 0);
    wr(2, 16'h0040); rd(2, q); check("R3 reset reg", q, 8'h1F);

    // R2/R5: sweep every counter value in interval mode
    wr(1, 16'h5A01);
    for (int v = 0; v < (1 << CW); v++) begin
      wr(0, {8'h5A, 8'(v)});
      tick1();
      check("R5 irq", int'(ival_irq_o), (v == (1 << CW) - 1) ? 1 : 0);
      rd(0, q); check("R2 increment", q, (v + 1) % (1 << CW));
      check("R5 irq one cycle", int'(ival_irq_o), 0);
    end
    rd(1, q); check("R5 run kept", q, 1);
    rd(2, q); check("R4 no flag in interval", q, 8'h1F);
    wr(1, 16'h5A00); wr(0, 16'h5A06); tick1();
    rd(0, q); check("R2 hold when stopped", q, 6);

    // R4/R6/R7/R9: watchdog wrap with both reset-enable settings
    for (int en = 0; en < 2; en++) begin
      pin_reset();
      if (en == 1) wr(2, 16'h5A40);
      wr(1, 16'h5A03);
      wr(0, 16'h5A0E);
      tick1();
      rd(2, q); check("R4 no flag before wrap", q, 8'h1F | (en << 6));
      tick1();
      n = 0;
      while (sys_rst_o && n < 100) begin n++; @(negedge clk); end
      check("R7 pulse length", n, (en == 1) ? PL : 0);
      check("R5 no irq in watchdog", int'(ival_irq_o), 0);
      rd(0, q); check("R6 counter cleared", q, 0);
      rd(1, q); check("R6 control cleared", q, 0);
      rd(2, q); check("R9 reset reg kept with flag", q, 8'h9F | (en << 6));
    end
    pin_reset();
    rd(2, q); check("R9 pin reset restores", q, 8'h1F);

    // R8 and reset type on the pulse
    wr(2, 16'h5A60); wr(1, 16'h5A03); wr(0, 16'h5A0F);
    tick1();
    check("R7 pulse high", int'(sys_rst_o), 1);
    check("R7 kind", int'(rst_kind_o), 1);
    wr(0, 16'h5A07);
    wr(1, 16'h5A01);
    check("R8 still in pulse", int'(sys_rst_o), 1);
    while (sys_rst_o) @(negedge clk);
    rd(0, q); check("R8 counter write ignored", q, 0);
    rd(1, q); check("R8 control write ignored", q, 0);
    wr(1, 16'h5A01); rd(1, q); check("R8 control writable after", q, 1);

    // R12: same-cycle set and clear
    pin_reset();
    wr(1, 16'h5A03); wr(0, 16'h5A0F); tick1();
    rd(2, q); check("R4 flag set", q, 8'h9F);
    wr(1, 16'h5A03); wr(0, 16'h5A0F);
    @(negedge clk);
    cnt_tick = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h5A00; bus_wr = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0; bus_wr = 1'b0;
    rd(2, q); check("R12 set wins", q, 8'h9F);

    // R10: clearing protocol (the read above arms it)
    wr(2, 16'h5A80); rd(2, q); check("R10 write 1 keeps flag", q, 8'h9F);
    wr(2, 16'h5A80);
    wr(2, 16'h5A00); rd(2, q); check("R10 no prior read", q, 8'h9F);
    wr(2, 16'h3300); rd(2, q); check("R3 bad key no clear", q, 8'h9F);
    wr(2, 16'h5A00); rd(2, q); check("R10 clear after read", q, 8'h1F);
    wr(2, 16'h5A80); rd(2, q); check("R10 write 1 never sets", q, 8'h1F);

    // R11
    wr(2, 16'h5A60); rd(2, q); check("R11 bits 6 and 5", q, 8'h7F);
    wr(2, 16'h5A00); rd(2, q); check("R11 low bits stay 1", q, 8'h1F);

    finish_run();
  end
endmodule